// File: doc/BRIEF.md
# Fractional-Divisor Sampling Clock Generator

This block turns a fast reference clock into the timing strobes that a UART transmitter and receiver need. The clock first passes through an optional prescaler that divides it by 1 or by 4. A divisor with a 16-bit integer part and a 4-bit fraction in sixteenths then divides the result. The output is a one-cycle sample strobe at 16, 8 or 4 times the serial bit rate, plus a bit strobe that marks every bit period.

The fraction is spread across periods by a small phase accumulator. Each period normally lasts the integer count of prescaled clocks. Some periods get one extra prescaled clock, so that over any run of sixteen periods exactly the fraction's value in extra clocks is added. Single periods therefore show a small jitter, and the long-run average is exact. The divisor comes in as three byte-wide setting inputs: integer low byte, integer high byte and fraction. Next to them are a prescaler select and a two-bit oversampling select. A new setting applies at the next strobe boundary.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst_n` is low both strobes are low. After release, with the prescaler bypassed, the first sample strobe is high in the first cycle after the first rising clock edge.
- R2: `presc_sel_i` = 0 feeds every reference cycle to the divisor. `presc_sel_i` = 1 feeds only every fourth cycle, so two sample strobes are never in adjacent cycles and every period is four times longer.
- R3: Any sixteen consecutive sample periods span exactly P × (16·N + F) reference cycles. P is 1 or 4 from the prescaler, N is the integer `{div_hi_i, div_lo_i}` and F is the fraction.
- R4: A single sample period lasts P·N or P·(N+1) cycles. It lasts exactly P·N when F is 0.
- R5: Only bits [3:0] of `div_frac_i` form the fraction. Bits [7:4] have no effect on the strobe timing.
- R6: An integer divisor of 0 behaves as 1, so sample strobes never stop.
- R7: The bit strobe fires once every 16 sample strobes when `samp_mode_i` = 2'b00, every 8 when it is 2'b01, and every 4 when it is 2'b10 or 2'b11.
- R8: A bit strobe is high only in the cycle right after a sample strobe.
- R9: A divisor change made during a period leaves that period at its old length. The new value sets the length of the period that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_lo_i | input | 8 | Integer divisor, low byte |
| div_hi_i | input | 8 | Integer divisor, high byte |
| div_frac_i | input | 8 | Fraction in sixteenths (bits [3:0] used) |
| presc_sel_i | input | 1 | 0: divide by 1, 1: divide by 4 |
| samp_mode_i | input | 2 | Oversampling: 00 = 16X, 01 = 8X, 1x = 4X |
| sample_tick_o | output | 1 | One-cycle sample strobe |
| bit_tick_o | output | 1 | One-cycle bit strobe |

## Verification
A sample strobe is registered. It is high in the cycle after the clock edge at which the period counter reaches zero on a prescaled enable. The bit strobe adds one more register and follows its sample strobe by one cycle. The bench drives its inputs and samples the outputs on falling edges, and counts the cycle distances between strobes as they appear. After each setting change it lets a few sample strobes and two bit strobes go by before it measures. It then compares spans of sixteen periods, which is exact despite the jitter, and checks each single period against its two allowed lengths. For the change-during-period case it measures the period in progress and the one after it separately.

// File: rtl/frac_brg_pkg.sv
package frac_brg_pkg;

    typedef enum logic [1:0] {
        OVS_16X   = 2'b00,
        OVS_8X    = 2'b01,
        OVS_4X    = 2'b10,
        OVS_4X_B  = 2'b11
    } ovs_mode_e;

    localparam int MAX_OVS = 16;
    localparam int OVS_W   = $clog2(MAX_OVS);

    function automatic logic [OVS_W-1:0] ovs_last(input ovs_mode_e m);
        case (m)
            OVS_16X: ovs_last = OVS_W'(15);
            OVS_8X:  ovs_last = OVS_W'(7);
            default: ovs_last = OVS_W'(3);
        endcase
    endfunction

endpackage

// File: rtl/brg_prescaler.sv
module brg_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    output logic en_o
);
    localparam int PC_W = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.pc == PC_W'(DIV - 1)) begin
            st_d.pc = '0;
        end else begin
            st_d.pc = st_q.pc + PC_W'(1);
        end
        en_o = sel_i ? (st_q.pc == PC_W'(DIV - 1)) : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/brg_frac_divider.sv
module brg_frac_divider #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [INT_W-1:0]  div_int_i,
    input  logic [FRAC_W-1:0] div_frac_i,
    output logic              tick_o
);
    typedef struct packed {
        logic [INT_W-1:0]  cnt;
        logic [FRAC_W-1:0] acc;
        logic              tick;
    } div_state_t;

    div_state_t st_d, st_q;

    logic [INT_W-1:0]  int_eff;
    logic [FRAC_W:0]   acc_sum;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        int_eff   = (div_int_i == '0) ? INT_W'(1) : div_int_i;
        acc_sum   = {1'b0, st_q.acc} + {1'b0, div_frac_i};
        if (en_i) begin
            if (st_q.cnt == '0) begin
                st_d.tick = 1'b1;
                st_d.cnt  = int_eff - INT_W'(1) + INT_W'(acc_sum[FRAC_W]);
                st_d.acc  = acc_sum[FRAC_W-1:0];
            end else begin
                st_d.cnt  = st_q.cnt - INT_W'(1);
            end
        end
        tick_o = st_q.tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/brg_bit_divider.sv
module brg_bit_divider
    import frac_brg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      samp_tick_i,
    input  ovs_mode_e mode_i,
    output logic      bit_tick_o
);
    typedef struct packed {
        logic [OVS_W-1:0] cnt;
        logic             tick;
    } bit_state_t;

    bit_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (samp_tick_i) begin
            if (st_q.cnt == '0) begin
                st_d.tick = 1'b1;
                st_d.cnt  = ovs_last(mode_i);
            end else begin
                st_d.cnt  = st_q.cnt - OVS_W'(1);
            end
        end
        bit_tick_o = st_q.tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import frac_brg_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int FRAC_W  = 4,
    parameter int PRE_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] div_lo_i,
    input  logic [BYTE_W-1:0] div_hi_i,
    input  logic [BYTE_W-1:0] div_frac_i,
    input  logic              presc_sel_i,
    input  logic [1:0]        samp_mode_i,
    output logic              sample_tick_o,
    output logic              bit_tick_o
);
    localparam int INT_W = 2 * BYTE_W;
    localparam logic [BYTE_W-1:0] FRAC_MASK = BYTE_W'((1 << FRAC_W) - 1);

    logic              pre_en;
    logic [INT_W-1:0]  div_int;
    logic [FRAC_W-1:0] frac_eff;

    assign div_int  = {div_hi_i, div_lo_i};
    assign frac_eff = FRAC_W'(div_frac_i & FRAC_MASK);

    brg_prescaler #(.DIV(PRE_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_i (presc_sel_i),
        .en_o  (pre_en)
    );

    brg_frac_divider #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (pre_en),
        .div_int_i  (div_int),
        .div_frac_i (frac_eff),
        .tick_o     (sample_tick_o)
    );

    brg_bit_divider u_bit (
        .clk         (clk),
        .rst_n       (rst_n),
        .samp_tick_i (sample_tick_o),
        .mode_i      (ovs_mode_e'(samp_mode_i)),
        .bit_tick_o  (bit_tick_o)
    );
endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
    parameter int BYTE_W  = 8,
    parameter int PRE_DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic presc_sel_i,
    input logic sample_tick_o,
    input logic bit_tick_o
);
    localparam longint MAX_GAP = longint'(PRE_DIV) * (longint'(1) << (2 * BYTE_W)) + PRE_DIV;

    logic [39:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (sample_tick_o) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + 40'd1;
        end
    end

    // R1: strobes stay low while reset is held
    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_quiet_in_reset: assert (!sample_tick_o && !bit_tick_o);
        end
    end

    // R2: with the divide-by-4 path held, sample strobes are never adjacent
    a_r2_presc_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(presc_sel_i) && $past(presc_sel_i, 2) && sample_tick_o) |-> !$past(sample_tick_o));

    // R8: a bit strobe follows a sample strobe
    a_r8_bit_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick_o |-> $past(sample_tick_o));

    // R6: sample strobes never stall beyond the longest legal period
    a_r6_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= 40'(MAX_GAP));
endmodule

bind frac_baud_gen frac_baud_gen_chk #(.BYTE_W(BYTE_W), .PRE_DIV(PRE_DIV)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .presc_sel_i   (presc_sel_i),
    .sample_tick_o (sample_tick_o),
    .bit_tick_o    (bit_tick_o)
);

// File: tb/frac_baud_gen_test.sv
module frac_baud_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_lo = 8'h01;
    logic [7:0] div_hi = 8'h00;
    logic [7:0] div_fr = 8'h00;
    logic       presc  = 1'b0;
    logic [1:0] mode   = 2'b00;
    logic       sample_tick_o;
    logic       bit_tick_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    frac_baud_gen uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .div_lo_i      (div_lo),
        .div_hi_i      (div_hi),
        .div_frac_i    (div_fr),
        .presc_sel_i   (presc),
        .samp_mode_i   (mode),
        .sample_tick_o (sample_tick_o),
        .bit_tick_o    (bit_tick_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // lo, hi, frac, presc, mode, bit strobes to span, sixteen-period span, bit span
    typedef struct packed {
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic [7:0]  fr;
        logic        pre;
        logic [1:0]  md;
        logic [7:0]  nb;
        logic [15:0] exp16;
        logic [15:0] expbit;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'd5, 8'd0, 8'h00, 1'b0, 2'b00, 8'd16, 16'd80,   16'd1280},
        '{8'd3, 8'd0, 8'h08, 1'b0, 2'b01, 8'd16, 16'd56,   16'd448},
        '{8'd2, 8'd0, 8'h0F, 1'b1, 2'b10, 8'd16, 16'd188,  16'd752},
        '{8'd7, 8'd0, 8'h05, 1'b1, 2'b00, 8'd16, 16'd468,  16'd7488},
        '{8'd0, 8'd0, 8'h00, 1'b0, 2'b01, 8'd16, 16'd16,   16'd128},
        '{8'd4, 8'd0, 8'hF3, 1'b0, 2'b10, 8'd16, 16'd67,   16'd268},
        '{8'd0, 8'd1, 8'h00, 1'b0, 2'b10, 8'd1,  16'd4096, 16'd1024},
        '{8'd1, 8'd0, 8'h01, 1'b0, 2'b11, 8'd16, 16'd17,   16'd68}
    };

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic next_samp(output int gap);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!sample_tick_o);
    endtask

    task automatic next_bit(output int gap);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!bit_tick_o);
    endtask

    initial begin
        int g;
        int g2;
        // R1: reset state
        repeat (4) begin
            @(negedge clk);
            check("R1 sample low in reset", sample_tick_o, 0);
            check("R1 bit low in reset", bit_tick_o, 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first sample strobe", sample_tick_o, 1);
        check("R8 no bit strobe yet", bit_tick_o, 0);
        @(negedge clk);
        check("R8 bit strobe one cycle later", bit_tick_o, 1);
        next_bit(g);
        check("R7 default 16X bit period", g, 16);

        for (int v = 0; v < NV; v++) begin
            int span;
            int lo_b;
            int hi_b;
            int p;
            int n;
            int bad;
            div_lo = VECS[v].lo;
            div_hi = VECS[v].hi;
            div_fr = VECS[v].fr;
            presc  = VECS[v].pre;
            mode   = VECS[v].md;
            p = VECS[v].pre ? 4 : 1;
            n = ({VECS[v].hi, VECS[v].lo} == 16'd0) ? 1 : int'({VECS[v].hi, VECS[v].lo});
            lo_b = p * n;
            hi_b = (VECS[v].fr[3:0] == 4'd0) ? p * n : p * (n + 1);
            repeat (3) next_samp(g);
            repeat (2) next_bit(g);
            next_samp(g);
            span = 0;
            bad = 0;
            for (int k = 0; k < 16; k++) begin
                next_samp(g);
                span += g;
                if (g != lo_b && g != hi_b) bad++;
            end
            // R3 R5 R6 R2: exact sixteen-period span
            check($sformatf("R3 vector %0d sixteen-period span", v), span, VECS[v].exp16);
            // R4: every single period within its two allowed lengths
            check($sformatf("R4 vector %0d out-of-range periods", v), bad, 0);
            next_bit(g);
            span = 0;
            for (int k = 0; k < int'(VECS[v].nb); k++) begin
                next_bit(g);
                span += g;
            end
            // R7: bit strobe spacing per oversampling mode
            check($sformatf("R7 vector %0d bit span", v), span, VECS[v].expbit);
        end

        // R5: upper fraction bits ignored (same span with 0x03 and 0xF3)
        div_lo = 8'd4; div_hi = 8'd0; div_fr = 8'h03; presc = 1'b0; mode = 2'b10;
        repeat (3) next_samp(g);
        next_samp(g);
        g2 = 0;
        for (int k = 0; k < 16; k++) begin
            next_samp(g);
            g2 += g;
        end
        check("R5 fraction 0x03 span", g2, 67);

        // R2: prescaler quadruples the period
        div_lo = 8'd3; div_fr = 8'h00; presc = 1'b1;
        repeat (3) next_samp(g);
        next_samp(g);
        check("R2 divide-by-4 period", g, 12);
        presc = 1'b0;
        repeat (3) next_samp(g);
        next_samp(g);
        check("R2 bypass period", g, 3);

        // R9: change during a period
        div_lo = 8'd8;
        repeat (3) next_samp(g);
        div_lo = 8'd3;
        next_samp(g);
        check("R9 running period keeps old length", g, 8);
        next_samp(g);
        check("R9 following period uses new length", g, 3);

        // R6: integer zero behaves as one
        div_lo = 8'd0;
        repeat (3) next_samp(g);
        next_samp(g);
        check("R6 zero divisor period", g, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule